// File: doc/BRIEF.md
# Four-Channel SPI Master Register Front End

This block is the 32-bit register file that sits between a word-addressed bus and a four-channel SPI master. It decodes a byte address into a set of global registers and four identical per-channel groups. It stores configuration, control and test values with per-register write masks. It answers reads, including two constant identification values. It also tells the channel engines about bus events that matter to them, using single-cycle strobes: TX word written, RX word read, and channel enable rising.

The serial shifting, interrupt aggregation and DMA logic live elsewhere. Their results arrive as inputs: the interrupt status word, the per-channel status set events and the received words. The stored settings leave as plain outputs.

Each bus access lasts one cycle, with `bus_valid_i` high. Read data returns one cycle after the access, qualified by `rd_valid_o`. A write to the system configuration register with bit 1 set performs a soft reset of all stored state.

Top module: `spi_regfile`

## Requirements
- R1: After reset, module control reads 4, every channel configuration reads 0x060000, every channel status reads 0x2, and every channel control, TX word, system configuration, interrupt enable, wakeup enable and system test register reads 0.
- R2: Address 0x00 reads the constant 0x91. Address 0x14 reads the constant 1. Channel n uses this map: configuration at 0x2C+0x14·n, status at 0x30+0x14·n, control at 0x34+0x14·n, TX at 0x38+0x14·n and RX at 0x3C+0x14·n.
- R3: Each register keeps only the written bits in its mask: system configuration (0x10) keeps 0x31D, interrupt enable (0x1C) keeps 0x1777F, wakeup enable (0x20) keeps bit 0, system test (0x24) keeps bits 11:0, module control (0x28) keeps bits 3:0, and channel configuration keeps bits 22:0.
- R4: Writes to 0x00, 0x14, any channel status address or any RX address change no stored value and raise no strobe.
- R5: A TX write stores the word, which then reads back at the same address. It clears channel status bit 1 (TX empty) and raises that channel's TX strobe. An engine TX-empty set event (`eng_txe_set_i`) sets bit 1 again, and an end-of-transfer event (`eng_eot_set_i`) sets bit 2.
- R6: An engine RX-full event (`eng_rxf_set_i`) sets channel status bit 0. An RX read returns that channel's `rx_word_i` slice, clears bit 0 and raises that channel's RX strobe.
- R7: Writing 1 to channel control bit 0 while it is 0 sets it and raises that channel's enable strobe. Any other write stores only bit 0 and raises no strobe.
- R8: A write to 0x10 with bit 1 set restores every R1 value. The system configuration register then holds the written value masked with 0x31D.
- R9: An access to an address outside the map, including a misaligned one, reads 0 and changes nothing.
- R10: Each strobe is high for exactly the one cycle after the edge that accepted the access, and at most one strobe bit is high at a time. Read data is valid in that same cycle.
- R11: Address 0x18 reads `irq_stat_i`. A write there drives `irq_ack_o` with the written word for one cycle; `irq_ack_o` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access in this cycle |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| irq_stat_i | input | 32 | Interrupt status from the aggregator |
| eng_txe_set_i | input | 4 | Per channel: set TX empty |
| eng_rxf_set_i | input | 4 | Per channel: set RX full |
| eng_eot_set_i | input | 4 | Per channel: set end of transfer |
| rx_word_i | input | 128 | Received word of channel n in bits 32n+31:32n |
| tx_wr_stb_o | output | 4 | TX written strobe per channel |
| rx_rd_stb_o | output | 4 | RX read strobe per channel |
| en_rise_stb_o | output | 4 | Enable rising strobe per channel |
| irq_ack_o | output | 32 | Interrupt clear mask, one cycle |
| sysconfig_o | output | 10 | Stored system configuration |
| irq_en_o | output | 17 | Stored interrupt enable |
| wake_en_o | output | 1 | Stored wakeup enable |
| systest_o | output | 12 | Stored system test |
| modctl_o | output | 4 | Stored module control |
| chan_cfg_o | output | 92 | Channel n configuration in bits 23n+22:23n |
| chan_en_o | output | 4 | Channel enable bits |
| tx_word_o | output | 128 | Channel n TX word in bits 32n+31:32n |

## Verification
The assertions assume that engine set events and bus accesses are synchronous to `clk`. When an engine sets a status bit in the same cycle that a bus access clears it, the set wins, so the clear checks only apply where no set occurred one edge earlier. The stimulus pulses each engine input for one cycle at a time, well apart from the bus accesses to the same channel. It issues only single-cycle accesses, so every strobe pulse can be tied to exactly one access.

// File: rtl/spi_regfile.sv
module spi_regfile (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_valid_i,
  input  logic         bus_write_i,
  input  logic [7:0]   bus_addr_i,
  input  logic [31:0]  bus_wdata_i,
  output logic         rd_valid_o,
  output logic [31:0]  rd_data_o,
  input  logic [31:0]  irq_stat_i,
  input  logic [3:0]   eng_txe_set_i,
  input  logic [3:0]   eng_rxf_set_i,
  input  logic [3:0]   eng_eot_set_i,
  input  logic [127:0] rx_word_i,
  output logic [3:0]   tx_wr_stb_o,
  output logic [3:0]   rx_rd_stb_o,
  output logic [3:0]   en_rise_stb_o,
  output logic [31:0]  irq_ack_o,
  output logic [9:0]   sysconfig_o,
  output logic [16:0]  irq_en_o,
  output logic         wake_en_o,
  output logic [11:0]  systest_o,
  output logic [3:0]   modctl_o,
  output logic [91:0]  chan_cfg_o,
  output logic [3:0]   chan_en_o,
  output logic [127:0] tx_word_o
);
  localparam int NCH = 4;
  localparam int CW  = 23;
  localparam logic [CW-1:0] CFG_RST = 23'h060000;
  localparam logic [9:0]  SCFG_MASK = 10'h31D;
  localparam logic [16:0] IEN_MASK  = 17'h1777F;

  logic [CW-1:0] cfg [NCH];
  logic [31:0]   tx  [NCH];
  logic [NCH-1:0] st_txe, st_rxf, st_eot;
  logic [NCH-1:0] hit_cfg, hit_st, hit_ctl, hit_tx, hit_rx;

  wire wr_acc = bus_valid_i &&  bus_write_i;
  wire rd_acc = bus_valid_i && !bus_write_i;

  wire hit_id   = bus_addr_i == 8'h00;
  wire hit_scfg = bus_addr_i == 8'h10;
  wire hit_sst  = bus_addr_i == 8'h14;
  wire hit_irqs = bus_addr_i == 8'h18;
  wire hit_irqe = bus_addr_i == 8'h1C;
  wire hit_wake = bus_addr_i == 8'h20;
  wire hit_test = bus_addr_i == 8'h24;
  wire hit_mctl = bus_addr_i == 8'h28;
  wire soft_rst = wr_acc && hit_scfg && bus_wdata_i[1];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit_cfg[n] = bus_addr_i == 8'(44 + 20*n);
    assign hit_st[n]  = bus_addr_i == 8'(48 + 20*n);
    assign hit_ctl[n] = bus_addr_i == 8'(52 + 20*n);
    assign hit_tx[n]  = bus_addr_i == 8'(56 + 20*n);
    assign hit_rx[n]  = bus_addr_i == 8'(60 + 20*n);
    assign chan_cfg_o[n*CW +: CW] = cfg[n];
    assign tx_word_o[n*32 +: 32]  = tx[n];
  end

  logic [31:0] rdata_c;
  always_comb begin
    rdata_c = '0;
    if (hit_id)   rdata_c = 32'h91;
    if (hit_scfg) rdata_c = {22'b0, sysconfig_o};
    if (hit_sst)  rdata_c = 32'h1;
    if (hit_irqs) rdata_c = irq_stat_i;
    if (hit_irqe) rdata_c = {15'b0, irq_en_o};
    if (hit_wake) rdata_c = {31'b0, wake_en_o};
    if (hit_test) rdata_c = {20'b0, systest_o};
    if (hit_mctl) rdata_c = {28'b0, modctl_o};
    for (int n = 0; n < NCH; n++) begin
      if (hit_cfg[n]) rdata_c = {9'b0, cfg[n]};
      if (hit_st[n])  rdata_c = {29'b0, st_eot[n], st_txe[n], st_rxf[n]};
      if (hit_ctl[n]) rdata_c = {31'b0, chan_en_o[n]};
      if (hit_tx[n])  rdata_c = tx[n];
      if (hit_rx[n])  rdata_c = rx_word_i[n*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;  rd_data_o <= '0;
      tx_wr_stb_o <= '0;   rx_rd_stb_o <= '0;  en_rise_stb_o <= '0;
      irq_ack_o <= '0;     sysconfig_o <= '0;  irq_en_o <= '0;
      wake_en_o <= 1'b0;   systest_o <= '0;    modctl_o <= 4'd4;
      chan_en_o <= '0;     st_txe <= '1;       st_rxf <= '0;  st_eot <= '0;
      for (int n = 0; n < NCH; n++) begin
        cfg[n] <= CFG_RST;
        tx[n]  <= '0;
      end
    end else if (soft_rst) begin
      rd_valid_o <= 1'b0;  rd_data_o <= '0;
      tx_wr_stb_o <= '0;   rx_rd_stb_o <= '0;  en_rise_stb_o <= '0;
      irq_ack_o <= '0;     sysconfig_o <= bus_wdata_i[9:0] & SCFG_MASK;
      irq_en_o <= '0;      wake_en_o <= 1'b0;  systest_o <= '0;
      modctl_o <= 4'd4;    chan_en_o <= '0;
      st_txe <= '1;        st_rxf <= '0;       st_eot <= '0;
      for (int n = 0; n < NCH; n++) begin
        cfg[n] <= CFG_RST;
        tx[n]  <= '0;
      end
    end else begin
      tx_wr_stb_o <= '0;  rx_rd_stb_o <= '0;  en_rise_stb_o <= '0;
      irq_ack_o <= '0;
      rd_valid_o <= rd_acc;
      if (rd_acc) rd_data_o <= rdata_c;
      if (wr_acc) begin
        if (hit_scfg) sysconfig_o <= bus_wdata_i[9:0] & SCFG_MASK;
        if (hit_irqs) irq_ack_o   <= bus_wdata_i;
        if (hit_irqe) irq_en_o    <= bus_wdata_i[16:0] & IEN_MASK;
        if (hit_wake) wake_en_o   <= bus_wdata_i[0];
        if (hit_test) systest_o   <= bus_wdata_i[11:0];
        if (hit_mctl) modctl_o    <= bus_wdata_i[3:0];
      end
      for (int n = 0; n < NCH; n++) begin
        if (wr_acc && hit_cfg[n]) cfg[n] <= bus_wdata_i[CW-1:0];
        if (wr_acc && hit_ctl[n]) begin
          if (bus_wdata_i[0] && !chan_en_o[n]) begin
            chan_en_o[n]     <= 1'b1;
            en_rise_stb_o[n] <= 1'b1;
          end else begin
            chan_en_o[n] <= bus_wdata_i[0];
          end
        end
        if (wr_acc && hit_tx[n]) begin
          tx[n]          <= bus_wdata_i;
          st_txe[n]      <= 1'b0;
          tx_wr_stb_o[n] <= 1'b1;
        end
        if (rd_acc && hit_rx[n]) begin
          st_rxf[n]      <= 1'b0;
          rx_rd_stb_o[n] <= 1'b1;
        end
        if (eng_txe_set_i[n]) st_txe[n] <= 1'b1;
        if (eng_rxf_set_i[n]) st_rxf[n] <= 1'b1;
        if (eng_eot_set_i[n]) st_eot[n] <= 1'b1;
      end
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_wr_stb_o, rx_rd_stb_o, en_rise_stb_o}));

  assert_rdvalid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(bus_valid_i && !bus_write_i));

  assert_ack_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o != '0) |-> $past(bus_valid_i && bus_write_i));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_en_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise_stb_o[n] |-> (chan_en_o[n] && !$past(chan_en_o[n])));
    assert_tx_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr_stb_o[n] && !$past(eng_txe_set_i[n])) |-> !st_txe[n]);
    assert_rx_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd_stb_o[n] && !$past(eng_rxf_set_i[n])) |-> !st_rxf[n]);
  end
endmodule

// File: tb/spi_regfile_bench.sv
module spi_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [7:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic rd_valid_o;
  logic [31:0] rd_data_o;
  logic [31:0] irq_stat_i = 32'h0000_1234;
  logic [3:0] eng_txe_set_i = '0, eng_rxf_set_i = '0, eng_eot_set_i = '0;
  logic [127:0] rx_word_i = {32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000};
  logic [3:0] tx_wr_stb_o, rx_rd_stb_o, en_rise_stb_o;
  logic [31:0] irq_ack_o;
  logic [9:0] sysconfig_o;
  logic [16:0] irq_en_o;
  logic wake_en_o;
  logic [11:0] systest_o;
  logic [3:0] modctl_o;
  logic [91:0] chan_cfg_o;
  logic [3:0] chan_en_o;
  logic [127:0] tx_word_o;

  spi_regfile u_spi_regfile (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid_i = 1'b0;
  endtask

  task automatic strobes(string tag, logic [11:0] e);
    chk(tag, {20'b0, tx_wr_stb_o, rx_rd_stb_o, en_rise_stb_o}, {20'b0, e});
  endtask

  always @(negedge clk) begin
    if (rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read data: got 0x%08h expected none", rd_data_o);
      end else begin
        chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h28, 32'h4, "R1 modctl reset");
    rd(8'h2C, 32'h060000, "R1 cfg0 reset");
    rd(8'h68, 32'h060000, "R1 cfg3 reset");
    rd(8'h58, 32'h2, "R1 status2 reset");
    rd(8'h70, 32'h0, "R1 ctrl3 reset");
    rd(8'h10, 32'h0, "R1 sysconfig reset");
    rd(8'h00, 32'h91, "R2 identification");
    rd(8'h14, 32'h1, "R2 sysstatus");

    wr(8'h10, 32'hFFFF_FFFD); rd(8'h10, 32'h31D, "R3 sysconfig mask");
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h1777F, "R3 irq enable mask");
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h1, "R3 wakeup mask");
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, 32'hFFF, "R3 system test mask");
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, 32'hF, "R3 modctl mask");
    wr(8'h54, 32'hFFFF_FFFF); rd(8'h54, 32'h7FFFFF, "R3 cfg2 mask");
    rd(8'h40, 32'h060000, "R2 cfg1 untouched by cfg2 write");

    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    strobes("R4 no strobe on RX write", 12'h000);
    rd(8'h00, 32'h91, "R4 identification unchanged");
    rd(8'h14, 32'h1, "R4 sysstatus unchanged");
    rd(8'h44, 32'h2, "R4 status1 unchanged");

    wr(8'h74, 32'hCAFE_F00D);
    strobes("R5 tx strobe ch3", 12'h800);
    @(negedge clk);
    strobes("R10 strobe lasts one cycle", 12'h000);
    rd(8'h74, 32'hCAFE_F00D, "R5 tx readback");
    rd(8'h6C, 32'h0, "R5 tx empty cleared");
    @(negedge clk); eng_txe_set_i = 4'b1000; eng_eot_set_i = 4'b1000;
    @(negedge clk); eng_txe_set_i = '0; eng_eot_set_i = '0;
    rd(8'h6C, 32'h6, "R5 engine sets txe and eot");

    @(negedge clk); eng_rxf_set_i = 4'b0001;
    @(negedge clk); eng_rxf_set_i = '0;
    rd(8'h30, 32'h3, "R6 rx full set");
    rd(8'h3C, 32'hA0A0_0000, "R6 rx word ch0");
    strobes("R6 rx strobe ch0", 12'h010);
    rd(8'h30, 32'h2, "R6 rx full cleared");
    rd(8'h64, 32'hC2C2_0002, "R6 rx word ch2");

    wr(8'h48, 32'h1);
    strobes("R7 enable rise ch1", 12'h002);
    rd(8'h48, 32'h1, "R7 enable stored");
    wr(8'h48, 32'hFFFF_FFFF);
    strobes("R7 no rise when already on", 12'h000);
    rd(8'h48, 32'h1, "R7 only bit0 kept");
    wr(8'h48, 32'h0);
    rd(8'h48, 32'h0, "R7 disable");
    wr(8'h48, 32'h1);

    wr(8'h2D, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    strobes("R9 no strobe on undecoded write", 12'h000);
    rd(8'h2C, 32'h060000, "R9 misaligned write ignored");
    rd(8'h04, 32'h0, "R9 hole reads zero");
    rd(8'h7C, 32'h0, "R9 past map reads zero");
    rd(8'h2E, 32'h0, "R9 misaligned read zero");

    rd(8'h18, 32'h0000_1234, "R11 irq status passthrough");
    wr(8'h18, 32'h0000_0055);
    chk("R11 irq ack pulse", irq_ack_o, 32'h55);
    @(negedge clk);
    chk("R11 irq ack returns to zero", irq_ack_o, 32'h0);

    wr(8'h10, 32'h0000_0012);
    rd(8'h10, 32'h10, "R8 sysconfig after soft reset");
    rd(8'h28, 32'h4, "R8 modctl restored");
    rd(8'h54, 32'h060000, "R8 cfg2 restored");
    rd(8'h74, 32'h0, "R8 tx word cleared");
    rd(8'h6C, 32'h2, "R8 status3 restored");
    rd(8'h48, 32'h0, "R8 enable cleared");
    rd(8'h1C, 32'h0, "R8 irq enable cleared");

    repeat (3) @(negedge clk);
    chk("R10 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule